// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 128-bit two's-complement adder whose carry chain is split into 8-bit segments. At every segment seam the carry either flows on to the next segment or is cut and replaced by a fresh lane carry-in. Cutting at every seam, every second, every fourth or every eighth seam turns the single wide adder into sixteen, eight, four or two independent additions or subtractions, all done in one pass.

A two-bit mode input selects the lane width and a single op bit selects add or subtract. Operands enter through a valid/ready handshake. By default the results pass through one output register that also takes part in that handshake. When the consumer holds `out_ready` low, the held result stays frozen and `in_ready` drops, so the producer must keep `in_valid` and its operands steady until it sees `in_ready` high. With `out_ready` high the block accepts a new operand set every cycle. Each result carries a packed sum and one carry-out bit per lane.

Top module: `simd_lane_adder`

## Requirements
- R1: `in_mode` picks the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives 64-bit. Lane j occupies bits [j*W+W-1 : j*W] of the operands and of `out_sum`, and the 128-bit word holds 128/W lanes.
- R2: With `in_sub`=0, every lane of `out_sum` is the sum of the matching lanes of A and B modulo 2^W. A carry out of one lane never reaches the next lane, so all-ones plus one in every lane gives zero in every lane.
- R3: With `in_sub`=1, every lane of `out_sum` is A minus B modulo 2^W, formed as A plus the inverted B plus a carry-in of 1 at that lane's lowest bit. The lane's carry-out is 1 exactly when A is at least B, read as unsigned numbers.
- R4: Bit j of `out_cout` is the carry out of the top bit of lane j. Bits j at or above 128/W are 0.
- R5: After reset, `out_valid` is 0, `out_sum` and `out_cout` are 0, and `in_ready` is 1.
- R6: An operand set accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_sum` and `out_cout`, with `out_valid` high, directly after that edge. It stays there until it is taken (`out_valid` and `out_ready` both high).
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and `out_sum` and `out_cout` hold their values.
- R8: With `out_ready` high, operand sets offered on consecutive cycles are all accepted, and their results appear on consecutive cycles in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_a | input | 128 | Packed operand A |
| in_b | input | 128 | Packed operand B |
| in_mode | input | 2 | Lane width select (see R1) |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 128 | Packed lane results |
| out_cout | output | 16 | Per-lane carry-out, lane 0 in bit 0 |

## Verification
Operands of all ones plus one are applied in every mode. In the right mode this wraps every lane to zero with a carry-out per lane, so a seam that leaks a carry, or is cut in the wrong mode, shows up at once. Mixed patterns with carries inside lanes check that segments that should join really do join. Subtracting equal operands, zero minus one and a random-looking pair check the inversion and the per-lane carry-in, along with the meaning of the carry-out. A stalled consumer followed by a back-to-back burst separates holding the output correctly from dropping or repeating results.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int unsigned SEG_W = 8;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10,
    LANE64 = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/lane_cut_gen.sv
module lane_cut_gen #(
  parameter int unsigned NSEG = 16
) (
  input  logic [1:0]      mode,
  output logic [NSEG-1:0] cut
);
  // A segment starts a lane when its index is a multiple of 2^mode.
  logic [2:0] lane_mask;
  assign lane_mask = 3'((4'd1 << mode) - 4'd1);

  for (genvar k = 0; k < NSEG; k++) begin : g_cut
    localparam logic [2:0] IDX = 3'(k % 8);
    assign cut[k] = ((IDX & lane_mask) == 3'd0);
  end
endmodule

// File: rtl/seg_add.sv
module seg_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cut,
  input  logic         chain_in,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic         cin;
  logic [W-1:0] b_eff;

  assign cin   = cut ? sub : chain_in;
  assign b_eff = b ^ {W{sub}};
  assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int unsigned DW = 128,
  parameter int unsigned CW = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_sum,
  input  logic [CW-1:0] in_cout,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_sum,
  output logic [CW-1:0] out_cout
);
  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [DW-1:0] sum_q;
    logic [CW-1:0] cout_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        sum_q  <= '0;
        cout_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          sum_q  <= in_sum;
          cout_q <= in_cout;
        end
      end
    end

    assign out_valid = vld_q;
    assign out_sum   = sum_q;
    assign out_cout  = cout_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_sum   = in_sum;
    assign out_cout  = in_cout;
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W  = 128,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned NSEG   = DATA_W / SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_mode,
  input  logic              in_sub,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_sum,
  output logic [NSEG-1:0]   out_cout
);
  logic [NSEG-1:0]   seg_cut;
  logic [NSEG-1:0]   seg_co;
  logic [NSEG:0]     chain;
  logic [DATA_W-1:0] sum_c;
  logic [NSEG-1:0]   lane_co;
  lane_mode_e        mode_e;

  assign mode_e = lane_mode_e'(in_mode);

  lane_cut_gen #(.NSEG(NSEG)) u_cut (
    .mode (in_mode),
    .cut  (seg_cut)
  );

  assign chain[0] = 1'b0;
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    seg_add #(.W(SEG_W)) u_seg (
      .a        (in_a[k*SEG_W +: SEG_W]),
      .b        (in_b[k*SEG_W +: SEG_W]),
      .sub      (in_sub),
      .cut      (seg_cut[k]),
      .chain_in (chain[k]),
      .sum      (sum_c[k*SEG_W +: SEG_W]),
      .cout     (seg_co[k])
    );
    assign chain[k+1] = seg_co[k];
  end

  // Gather the carry of each lane's top segment into a packed lane vector.
  for (genvar j = 0; j < NSEG; j++) begin : g_lco
    always_comb begin
      lane_co[j] = 1'b0;
      unique case (mode_e)
        LANE8:  lane_co[j] = seg_co[j];
        LANE16: if (2*j+1 < NSEG) lane_co[j] = seg_co[(2*j+1) % NSEG];
        LANE32: if (4*j+3 < NSEG) lane_co[j] = seg_co[(4*j+3) % NSEG];
        LANE64: if (8*j+7 < NSEG) lane_co[j] = seg_co[(8*j+7) % NSEG];
        default: lane_co[j] = 1'b0;
      endcase
    end
  end

  simd_out_stage #(.DW(DATA_W), .CW(NSEG), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sum    (sum_c),
    .in_cout   (lane_co),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sum   (out_sum),
    .out_cout  (out_cout)
  );
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned NSEG   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_sum,
  input logic [NSEG-1:0]   out_cout,
  input logic [NSEG-1:0]   seg_cut
);
  // R1: lane starts match the chosen width
  assert_lane_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_cut) == (NSEG >> in_mode));

  assert_low_seg_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg_cut[0]);

  assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_sum) && $stable(out_cout)));

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_flow_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

bind simd_lane_adder simd_lane_adder_chk #(.DATA_W(DATA_W), .NSEG(NSEG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sum   (out_sum),
  .out_cout  (out_cout),
  .seg_cut   (seg_cut)
);

// File: tb/test_simd_lane_adder.sv
`timescale 1ns/1ps
module test_simd_lane_adder;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic [1:0]   in_mode = 2'b00;
  logic         in_sub = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_sum;
  logic [15:0]  out_cout;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  simd_lane_adder i_simd_lane_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_cout(out_cout)
  );

  // Bit-serial model: carry restarts at each lane's lowest bit.
  task automatic model(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] m, input logic s,
                       output logic [127:0] sm, output logic [15:0] co);
    int w;
    logic c, bb;
    w = 8 << m;
    sm = '0; co = '0; c = 1'b0;
    for (int i = 0; i < 128; i++) begin
      if (i % w == 0) c = s;
      bb = b[i] ^ s;
      sm[i] = a[i] ^ bb ^ c;
      c = (a[i] & bb) | (a[i] & c) | (bb & c);
      if (i % w == w - 1) co[i / w] = c;
    end
  endtask

  task automatic check_out(input string tag, input logic [127:0] es, input logic [15:0] ec);
    total++;
    if (out_valid !== 1'b1 || out_sum !== es || out_cout !== ec) begin
      bad++;
      $display("FAIL %s: valid=%b sum=%h cout=%h expected valid=1 sum=%h cout=%h",
               tag, out_valid, out_sum, out_cout, es, ec);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] a, input logic [127:0] b,
                       input logic [1:0] m, input logic s);
    in_a = a; in_b = b; in_mode = m; in_sub = s; in_valid = 1'b1;
  endtask

  task automatic one_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] m, input logic s);
    logic [127:0] es; logic [15:0] ec;
    model(a, b, m, s, es, ec);
    @(negedge clk);
    drive(a, b, m, s);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(tag, es, ec);
  endtask

  task automatic t_reset();
    total++;
    if (out_valid !== 1'b0 || out_sum !== '0 || out_cout !== '0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R5: valid=%b sum=%h cout=%h ready=%b expected 0/0/0/1",
               out_valid, out_sum, out_cout, in_ready);
    end
  endtask

  task automatic t_carry_wall();
    // all ones + 1 in each lane of the chosen width: every lane wraps to zero
    one_op("R2 8-bit wrap", {128{1'b1}}, {16{8'h01}}, 2'b00, 1'b0);
    one_op("R1 16-bit wrap", {128{1'b1}}, {8{16'h0001}}, 2'b01, 1'b0);
    one_op("R1 32-bit wrap", {128{1'b1}}, {4{32'h1}}, 2'b10, 1'b0);
    one_op("R4 64-bit wrap", {128{1'b1}}, {2{64'h1}}, 2'b11, 1'b0);
  endtask

  task automatic t_add_mix();
    logic [127:0] pa, pb;
    pa = 128'h80FF_7F01_FFFF_0000_1234_5678_9ABC_DEF0;
    pb = 128'h80_01_81_FF_0001_FFFF_EDCB_A987_6543_2110;
    one_op("R2 mix 8-bit", pa, pb, 2'b00, 1'b0);
    one_op("R2 mix 16-bit", pa, pb, 2'b01, 1'b0);
    one_op("R1 mix 32-bit", pa, pb, 2'b10, 1'b0);
    one_op("R4 mix 64-bit", pa, pb, 2'b11, 1'b0);
  endtask

  task automatic t_sub();
    logic [127:0] pa;
    pa = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
    one_op("R3 equal 8-bit", pa, pa, 2'b00, 1'b1);
    one_op("R3 zero minus one 16-bit", '0, {8{16'h0001}}, 2'b01, 1'b1);
    one_op("R3 mix 32-bit", pa, 128'h1111_FFFF_0123_4568_0000_0001_F00D_CAFF, 2'b10, 1'b1);
    one_op("R3 mix 64-bit", 128'h1, 128'h2_0000_0000_0000_0000, 2'b11, 1'b1);
  endtask

  task automatic t_stall();
    logic [127:0] s1, s2; logic [15:0] c1, c2;
    model(128'h0102, 128'h0304, 2'b00, 1'b0, s1, c1);
    model({128{1'b1}}, 128'h5, 2'b11, 1'b0, s2, c2);
    @(negedge clk);
    out_ready = 1'b0;
    drive(128'h0102, 128'h0304, 2'b00, 1'b0);
    @(negedge clk);
    check_out("R6 first result held", s1, c1);
    drive({128{1'b1}}, 128'h5, 2'b11, 1'b0);
    check_bit("R7 in_ready low under stall", in_ready, 1'b0);
    @(negedge clk);
    check_out("R7 result stable under stall", s1, c1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R6 queued operand after release", s2, c2);
  endtask

  task automatic t_burst();
    logic [127:0] s1, s2, s3; logic [15:0] c1, c2, c3;
    model(128'hFF, 128'h01, 2'b00, 1'b0, s1, c1);
    model(128'hFF, 128'h01, 2'b01, 1'b0, s2, c2);
    model(128'h00, 128'h01, 2'b10, 1'b1, s3, c3);
    @(negedge clk);
    drive(128'hFF, 128'h01, 2'b00, 1'b0);
    @(negedge clk);
    check_out("R8 burst 1", s1, c1);
    drive(128'hFF, 128'h01, 2'b01, 1'b0);
    @(negedge clk);
    check_out("R8 burst 2", s2, c2);
    drive(128'h00, 128'h01, 2'b10, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R8 burst 3", s3, c3);
    @(negedge clk);
    check_bit("R6 valid drops after take", out_valid, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_carry_wall();
    t_add_mix();
    t_sub();
    t_stall();
    t_burst();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule